// File: doc/BRIEF.md
# I2C-Controlled Eight-Pin GPIO Expander

This block is an I2C target that gives a bus master control of eight general-purpose pins through four byte-wide registers. The bus lines are oversampled in the system clock domain. SDA is driven open-drain: the block only ever asserts `sda_oe` to pull the line low and never drives it high. The 7-bit target address is a static input.

Each transaction starts with the address byte. When the master writes, the first byte after the address is a command. Its two low bits point at one register: the sampled pin levels, the output values, the polarity mask or the direction mask. Any further write bytes land in the register that the pointer selects. A read returns the selected register for as long as the master keeps acknowledging. The pointer survives STOP and repeated START, so a master can write only the command byte and then read the register with a repeated START. Each pin's output enable comes from the direction mask and its output value from the output register.

There is no streaming data path at the block's edge. The pins and the bus lines are plain level signals, so no valid/ready handshake or back-pressure applies.

Top module: `gpio_expander_i2c`

## Requirements
- R1: After reset the output register holds 0xFF, the polarity register 0x00 and the direction register 0xFF. So `pin_oe` is 0x00, `pin_o` is 0xFF and `sda_oe` is 0.
- R2: After a START, the block acknowledges an address byte whose upper seven bits equal `dev_addr`, and in a write it acknowledges every later byte. For any other address it gives no acknowledge and leaves SDA released until the next START, and no register changes.
- R3: The first byte written after the address is a command, and its two low bits select the register: 0 = pin input, 1 = output, 2 = polarity, 3 = direction. Every later write byte goes to that register, and reads return it.
- R4: Bits 7:2 of the command byte are ignored.
- R5: Writes that target register 0 are acknowledged but change no register.
- R6: Reading register 0 returns `pin_i` XOR polarity register: a polarity bit of 1 inverts that pin, a bit of 0 passes it through. This holds whatever the pin's direction.
- R7: `pin_oe[i]` is high exactly when direction bit i is 0, and `pin_o` equals the output register. Both change only through a register write.
- R8: In a read the block sends eight bits MSB first and releases SDA for the ninth clock. When the master acknowledges, it sends the same register again, because the pointer does not advance.
- R9: After the master gives no acknowledge on a read, the block releases SDA and ignores START conditions until a STOP, after which it answers normally.
- R10: The register pointer is kept across STOP and repeated START.
- R11: An acknowledge from the block holds SDA low for the whole high phase of the ninth SCL clock. The block changes `sda_oe` only while SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Static 7-bit target address |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| pin_i | input | 8 | Levels present on the eight pins |
| pin_o | output | 8 | Output value for each pin |
| pin_oe | output | 8 | Output enable for each pin, high drives |

## Verification
The bench goes after the edges of the pointer. It writes with commands above 0x03, which a design that decoded the full byte would send to no register or to the wrong one. It writes only a command and then reads across a STOP, which a design that cleared the pointer would answer with register 0. It writes to register 0, which a design that treated that register as writable would let corrupt the pins.

On the bus side it probes a wrong address, where a careless design would still acknowledge or write. It probes a master NACK followed by a repeated START, where a design that ignored the halt would acknowledge. It probes multi-byte reads, where an auto-incrementing design would return a different register. A reference model of the pins is compared on every clock, so a pin that changed outside a register write shows up at once.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 4;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef logic [PTR_W-1:0] reg_ptr_t;

  localparam reg_ptr_t PTR_INPUT    = 2'd0;
  localparam reg_ptr_t PTR_OUTPUT   = 2'd1;
  localparam reg_ptr_t PTR_POLARITY = 2'd2;
  localparam reg_ptr_t PTR_DIR      = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_HALT
  } bus_state_t;
endpackage

// File: rtl/gx_bus_sense.sv
module gx_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/gx_link.sv
module gx_link
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output reg_ptr_t          wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output reg_ptr_t          rd_sel
);
  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              got_addr, is_read, first_byte, mack_ok;
  reg_ptr_t          ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      got_addr   <= 1'b0;
      is_read    <= 1'b0;
      first_byte <= 1'b1;
      mack_ok    <= 1'b0;
      ptr        <= PTR_INPUT;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det && state != ST_HALT) begin
        state      <= ST_RECV;
        got_addr   <= 1'b0;
        first_byte <= 1'b1;
        cnt        <= '0;
        sda_oe     <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              if (!got_addr) begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  got_addr <= 1'b1;
                  is_read  <= shreg[0];
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (first_byte) begin
                  ptr        <= shreg[PTR_W-1:0];
                  first_byte <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= CNT_W'(1);
                state  <= ST_SEND;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RECV;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (cnt < CNT_W'(BYTE_W)) begin
                sda_oe <= ~shreg[BYTE_W-2];
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_ok) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= CNT_W'(1);
                state  <= ST_SEND;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_HALT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_sel = ptr;
  assign rd_sel = ptr;

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe);
  assert_halt_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |-> !sda_oe);
  assert_ack_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ACK |-> sda_oe);
  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));
endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_ptr_t          wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  reg_ptr_t          rd_sel,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe
);
  logic [BYTE_W-1:0] out_q, pol_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        PTR_OUTPUT:   out_q <= wr_data;
        PTR_POLARITY: pol_q <= wr_data;
        PTR_DIR:      dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      PTR_INPUT:    rd_data = pin_i ^ pol_q;
      PTR_OUTPUT:   rd_data = out_q;
      PTR_POLARITY: rd_data = pol_q;
      default:      rd_data = dir_q;
    endcase
  end

  assign pin_o  = out_q;
  assign pin_oe = ~dir_q;

  assert_input_reg_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == PTR_INPUT) |=> ($stable(pin_o) && $stable(pin_oe) && $stable(pol_q)));
  assert_pins_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_o) && $stable(pin_oe)));
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c
  import gx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  reg_ptr_t wr_sel, rd_sel;
  logic [BYTE_W-1:0] wr_data, rd_data;

  gx_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  gx_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .dev_addr(dev_addr), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel)
  );

  gx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .pin_i(pin_i), .rd_data(rd_data),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );
endmodule

// File: tb/test_gpio_expander_i2c.sv
module test_gpio_expander_i2c;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  localparam logic [6:0] ADDR = 7'h27;

  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] pins = 8'hA5;
  logic [7:0] pin_o, pin_oe;
  wire        sda_line = sda_m & ~sda_oe;

  gpio_expander_i2c i_gpio_expander_i2c (
    .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .pin_i(pins), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // reference model
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF;
  logic [1:0] m_ptr = 2'd0;
  logic       hold_cmp = 1'b1;
  int checks = 0;
  int fails = 0;

  function automatic logic [7:0] model_reg(input logic [1:0] p);
    case (p)
      2'd0: return pins ^ m_pol;
      2'd1: return m_out;
      2'd2: return m_pol;
      default: return m_dir;
    endcase
  endfunction

  // R7: pins compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !hold_cmp) begin
      checks++;
      if (pin_o !== m_out || pin_oe !== ~m_dir) begin
        fails++;
        $display("FAIL R7 pins: pin_o=%h pin_oe=%h expected %h %h", pin_o, pin_oe, m_out, ~m_dir);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic s, output logic se, output logic sl);
    sda_m = b; wt(5);
    scl = 1'b1; wt(1); se = sda_line;
    wt(4); s = sda_line;
    wt(4); sl = sda_line;
    wt(1); scl = 1'b0; wt(5);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(5);
    scl = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl = 1'b0; wt(5);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(5);
    scl = 1'b1; wt(10);
    sda_m = 1'b1; wt(10);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit hold_last, output logic ack);
    logic s, se, sl;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && hold_last) hold_cmp = 1'b1;
      bit_cycle(b[i], s, se, sl);
    end
    bit_cycle(1'b1, s, se, sl);
    ack = ~s;
    if (!s) chk(se == 1'b0 && sl == 1'b0, "R11 ack low whole high phase", {se, sl}, 0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s, se, sl;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, s, se, sl);
      d = {d[6:0], s};
    end
    bit_cycle(~mack, s, se, sl);
  endtask

  task automatic send_data(input logic [7:0] d);
    logic ack;
    send_byte(d, 1'b1, ack);
    chk(ack, "R2 data byte acked", ack, 1);
    case (m_ptr)
      2'd1: m_out = d;
      2'd2: m_pol = d;
      2'd3: m_dir = d;
      default: ;
    endcase
    hold_cmp = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] d);
    logic ack;
    start_c();
    send_byte({ADDR, 1'b0}, 1'b0, ack);
    chk(ack, "R2 address acked", ack, 1);
    send_byte(cmd, 1'b0, ack);
    chk(ack, "R3 command acked", ack, 1);
    m_ptr = cmd[1:0];
    send_data(d);
    stop_c();
  endtask

  task automatic do_read(input logic [7:0] cmd, input string req);
    logic ack;
    logic [7:0] d;
    start_c();
    send_byte({ADDR, 1'b0}, 1'b0, ack);
    chk(ack, "R2 address acked", ack, 1);
    send_byte(cmd, 1'b0, ack);
    m_ptr = cmd[1:0];
    start_c();
    send_byte({ADDR, 1'b1}, 1'b0, ack);
    chk(ack, "R2 read address acked", ack, 1);
    recv_byte(1'b0, d);
    chk(d == model_reg(m_ptr), req, d, model_reg(m_ptr));
    stop_c();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    wt(4);
    // R1 reset state
    chk(sda_oe == 1'b0 && pin_oe == 8'h00 && pin_o == 8'hFF, "R1 reset outputs",
        {sda_oe, pin_oe, pin_o}, {1'b0, 8'h00, 8'hFF});
    rst_n = 1'b1;
    wt(4);
    hold_cmp = 1'b0;
    do_read(8'h01, "R1 output default");
    do_read(8'h02, "R1 polarity default");
    do_read(8'h03, "R1 direction default");
    do_read(8'h00, "R6 input with zero polarity");

    // R3 / R7 writes drive pins
    do_write(8'h01, 8'h3C);
    do_write(8'h03, 8'h0F);
    chk(pin_oe == 8'hF0 && pin_o == 8'h3C, "R7 pin drive after writes", {pin_oe, pin_o}, {8'hF0, 8'h3C});
    do_read(8'h01, "R3 output readback");
    do_read(8'h03, "R3 direction readback");

    // R5 input register read-only
    do_write(8'h00, 8'h00);
    chk(pin_o == 8'h3C && pin_oe == 8'hF0, "R5 write to input ignored", {pin_o, pin_oe}, {8'h3C, 8'hF0});
    do_read(8'h00, "R5 input still shows pins");

    // R6 polarity inversion regardless of direction
    do_write(8'h02, 8'hFF);
    do_read(8'h00, "R6 inverted input");
    pins = 8'h5A; wt(5);
    do_write(8'h02, 8'h0F);
    do_read(8'h00, "R6 partial inversion");

    // R4 command masking
    do_write(8'h06, 8'h81);
    do_read(8'h02, "R4 masked command hits polarity");
    do_write(8'hFD, 8'h42);
    do_read(8'hF1, "R4 masked command hits output");

    // R2 address mismatch
    start_c();
    send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, ack);
    chk(!ack, "R2 wrong address not acked", ack, 0);
    send_byte(8'h01, 1'b0, ack);
    chk(!ack, "R2 bytes after mismatch not acked", ack, 0);
    send_byte(8'h00, 1'b0, ack);
    chk(sda_oe == 1'b0 && pin_o == m_out, "R2 no write after mismatch", {sda_oe, pin_o}, {1'b0, m_out});
    stop_c();

    // R10 pointer retained across STOP
    start_c();
    send_byte({ADDR, 1'b0}, 1'b0, ack);
    send_byte(8'h03, 1'b0, ack);
    m_ptr = 2'd3;
    stop_c();
    start_c();
    send_byte({ADDR, 1'b1}, 1'b0, ack);
    chk(ack, "R10 read address acked", ack, 1);
    recv_byte(1'b0, d);
    chk(d == m_dir, "R10 pointer kept over STOP", d, m_dir);
    stop_c();

    // R3 multi-byte write, R8 multi-byte read without auto-increment
    start_c();
    send_byte({ADDR, 1'b0}, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    m_ptr = 2'd1;
    send_data(8'h11);
    send_data(8'hE7);
    stop_c();
    start_c();
    send_byte({ADDR, 1'b1}, 1'b0, ack);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, d);
      chk(d == 8'hE7, "R8 repeated read of same register", d, 8'hE7);
    end
    stop_c();

    // R9 NACK halts until STOP, repeated START ignored
    start_c();
    send_byte({ADDR, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, d);
    chk(d == m_out, "R8 read data", d, m_out);
    start_c();
    send_byte({ADDR, 1'b0}, 1'b0, ack);
    chk(!ack, "R9 START ignored after NACK", ack, 0);
    chk(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);
    stop_c();
    do_read(8'h03, "R9 normal after STOP");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule